// File: doc/BRIEF.md
# Serial Synthesizer Configuration Loader

This block receives configuration words for a frequency synthesizer over a three-wire serial link: a data line, a bit clock and a load strobe. All three lines are sampled with the block's own system clock. Each synchronized rising edge of the bit clock moves one data bit into a shift register.

The last bit shifted in is a routing flag. When the load strobe rises, the flag selects the destination for the shift-register contents. One destination is the reference word: a 14-bit reference divide ratio and a prescaler-mode select. The other destination is the loop divider word: an 11-bit main count and a 7-bit swallow count.

The two words have different lengths, but both arrive on the same stream. A reference ratio below the legal minimum is never latched. Instead, the previous reference word is kept and an error flag is raised. The latched words are presented as parallel outputs for the divider counters, which live outside this block.

Top module: `synth_prog_if`

## Requirements
- R1: After reset, ref_ratio is 8, presc_sel is 0, swallow_cnt is 0, main_cnt is 0 and cfg_err is 0.
- R2: Bits enter the shift register only on a rising edge of ser_clk. Toggling ser_data with ser_clk held still does not change the word that the next load delivers.
- R3: A load whose last bit is 1 is a reference word, shifted as: prescaler select, then R bits 13 down to 0, then the 1. It sets ref_ratio and presc_sel and leaves swallow_cnt and main_cnt unchanged.
- R4: A load whose last bit is 0 is a divider word, shifted as: main count bits 10 down to 0, then swallow bits 6 down to 0, then the 0. It sets main_cnt and swallow_cnt and leaves ref_ratio and presc_sel unchanged.
- R5: A reference word with R below 8 leaves ref_ratio and presc_sel unchanged and sets cfg_err to 1.
- R6: An accepted reference load clears cfg_err. A divider load leaves cfg_err unchanged.
- R7: Exactly one transfer happens for each rising edge of ser_le. Bits shifted while ser_le stays high do not reach the latches until ser_le falls and rises again. The outputs change only on a transfer.
- R8: The R values 8 and 16383 are accepted. The values 7 and 0 are rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock; a bit is taken on its rising edge |
| ser_data | input | 1 | Serial data bit |
| ser_le | input | 1 | Load strobe; its rising edge transfers the shift register |
| ref_ratio | output | 14 | Latched reference divide ratio |
| presc_sel | output | 1 | Latched prescaler mode select |
| swallow_cnt | output | 7 | Latched swallow count |
| main_cnt | output | 11 | Latched main count |
| cfg_err | output | 1 | Set by a rejected reference load |

## Verification
The checker assumes that each level on the serial lines lasts at least a few system clocks. This lets every edge survive the synchronizer as exactly one detected edge. The bench holds every level of ser_clk, ser_data and ser_le for four to six system clocks, so it stays well inside that assumption. The checker also assumes that a transfer and a bit shift may fall in the same cycle; in that case the transfer uses the contents from before the shift. The bench never makes the two coincide, so its expected words do not depend on that ordering.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

   typedef enum logic [1:0] {
      XFER_NONE    = 2'd0,
      XFER_REF     = 2'd1,
      XFER_REF_BAD = 2'd2,
      XFER_DIV     = 2'd3
   } xfer_kind_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic level,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              last_q;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= 1'b0;
               else        chain[gi] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= 1'b0;
               else        chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[STAGES-1];
   end

   assign level = chain[STAGES-1];
   assign rise  = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/serial_shifter.sv
module serial_shifter #(
   parameter int unsigned SR_W = 19
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            shift_en,
   input  logic            bit_in,
   output logic [SR_W-1:0] sr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sr <= '0;
      else if (shift_en) sr <= {sr[SR_W-2:0], bit_in};
   end
endmodule

// File: rtl/xfer_decode.sv
module xfer_decode
   import synth_prog_pkg::*;
#(
   parameter int unsigned SR_W  = 19,
   parameter int unsigned R_W   = 14,
   parameter int unsigned R_MIN = 8
) (
   input  logic            load,
   input  logic [SR_W-1:0] sr,
   output xfer_kind_e      kind
);
   localparam logic [R_W-1:0] R_FLOOR = R_W'(R_MIN);

   logic [R_W-1:0] r_field;
   assign r_field = sr[R_W:1];

   always_comb begin
      kind = XFER_NONE;
      if (load) begin
         if (!sr[0])               kind = XFER_DIV;
         else if (r_field < R_FLOOR) kind = XFER_REF_BAD;
         else                      kind = XFER_REF;
      end
   end
endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank
   import synth_prog_pkg::*;
#(
   parameter int unsigned SR_W       = 19,
   parameter int unsigned R_W        = 14,
   parameter int unsigned A_W        = 7,
   parameter int unsigned N_W        = 11,
   parameter int unsigned R_MIN      = 8,
   parameter bit          ERR_STICKY = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  xfer_kind_e      kind,
   input  logic [SR_W-1:0] sr,
   output logic [R_W-1:0]  ref_ratio,
   output logic            presc_sel,
   output logic [A_W-1:0]  swallow_cnt,
   output logic [N_W-1:0]  main_cnt,
   output logic            cfg_err
);
   localparam int unsigned SW_POS = R_W + 1;
   localparam int unsigned N_LO   = A_W + 1;
   localparam int unsigned N_HI   = A_W + N_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_ratio <= R_W'(R_MIN);
         presc_sel <= 1'b0;
      end else if (kind == XFER_REF) begin
         ref_ratio <= sr[R_W:1];
         presc_sel <= sr[SW_POS];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         swallow_cnt <= '0;
         main_cnt    <= '0;
      end else if (kind == XFER_DIV) begin
         swallow_cnt <= sr[A_W:1];
         main_cnt    <= sr[N_HI:N_LO];
      end
   end

   generate
      if (ERR_STICKY) begin : g_err_sticky
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    cfg_err <= 1'b0;
            else if (kind == XFER_REF_BAD) cfg_err <= 1'b1;
         end
      end else begin : g_err_clearable
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    cfg_err <= 1'b0;
            else if (kind == XFER_REF_BAD) cfg_err <= 1'b1;
            else if (kind == XFER_REF)     cfg_err <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
   import synth_prog_pkg::*;
#(
   parameter int unsigned R_W         = 14,
   parameter int unsigned A_W         = 7,
   parameter int unsigned N_W         = 11,
   parameter int unsigned R_MIN       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          ERR_STICKY  = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ser_clk,
   input  logic           ser_data,
   input  logic           ser_le,
   output logic [R_W-1:0] ref_ratio,
   output logic           presc_sel,
   output logic [A_W-1:0] swallow_cnt,
   output logic [N_W-1:0] main_cnt,
   output logic           cfg_err
);
   localparam int unsigned SR_W = max_u(R_W + 1, A_W + N_W) + 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (R_MIN < 1 || R_MIN >= (1 << R_W)) begin : g_bad_rmin
         $error("R_MIN must lie within the reference field range");
      end
      if (R_W < 2 || A_W < 1 || N_W < 1) begin : g_bad_width
         $error("field widths too small");
      end
   endgenerate

   logic            clk_lvl, clk_rise;
   logic            le_lvl, le_rise;
   logic            dat_lvl, dat_rise;
   logic [SR_W-1:0] sr;
   xfer_kind_e      kind;

   edge_sync #(.STAGES(SYNC_STAGES)) i_sync_clk (
      .clk(clk), .rst_n(rst_n), .async_in(ser_clk), .level(clk_lvl), .rise(clk_rise));

   edge_sync #(.STAGES(SYNC_STAGES)) i_sync_le (
      .clk(clk), .rst_n(rst_n), .async_in(ser_le), .level(le_lvl), .rise(le_rise));

   edge_sync #(.STAGES(SYNC_STAGES)) i_sync_dat (
      .clk(clk), .rst_n(rst_n), .async_in(ser_data), .level(dat_lvl), .rise(dat_rise));

   serial_shifter #(.SR_W(SR_W)) i_shift (
      .clk(clk), .rst_n(rst_n), .shift_en(clk_rise), .bit_in(dat_lvl), .sr(sr));

   xfer_decode #(.SR_W(SR_W), .R_W(R_W), .R_MIN(R_MIN)) i_dec (
      .load(le_rise), .sr(sr), .kind(kind));

   cfg_latch_bank #(
      .SR_W(SR_W), .R_W(R_W), .A_W(A_W), .N_W(N_W),
      .R_MIN(R_MIN), .ERR_STICKY(ERR_STICKY)
   ) i_latch (
      .clk(clk), .rst_n(rst_n), .kind(kind), .sr(sr),
      .ref_ratio(ref_ratio), .presc_sel(presc_sel),
      .swallow_cnt(swallow_cnt), .main_cnt(main_cnt), .cfg_err(cfg_err));

   logic unused_lvls;
   assign unused_lvls = clk_lvl ^ le_lvl ^ dat_rise;
endmodule

// File: rtl/synth_prog_if_chk.sv
module synth_prog_if_chk #(
   parameter int unsigned R_W   = 14,
   parameter int unsigned A_W   = 7,
   parameter int unsigned N_W   = 11,
   parameter int unsigned R_MIN = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic           le_rise,
   input logic           ctrl_bit,
   input logic [R_W-1:0] sr_ratio,
   input logic [R_W-1:0] ref_ratio,
   input logic           presc_sel,
   input logic [A_W-1:0] swallow_cnt,
   input logic [N_W-1:0] main_cnt,
   input logic           cfg_err
);
   localparam logic [R_W-1:0] FLOOR = R_W'(R_MIN);

   // R7: no transfer, no output change
   p_hold_no_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !le_rise |=> ($stable(ref_ratio) && $stable(presc_sel) && $stable(swallow_cnt)
                    && $stable(main_cnt) && $stable(cfg_err)));

   p_ref_keeps_div_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (le_rise && ctrl_bit) |=> ($stable(swallow_cnt) && $stable(main_cnt)));

   p_div_keeps_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (le_rise && !ctrl_bit) |=> ($stable(ref_ratio) && $stable(presc_sel) && $stable(cfg_err)));

   p_reject_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (le_rise && ctrl_bit && sr_ratio < FLOOR) |=> ($stable(ref_ratio) && cfg_err));

   p_good_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (le_rise && ctrl_bit && sr_ratio >= FLOOR) |=> (!cfg_err && ref_ratio == $past(sr_ratio)));

   p_ratio_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ref_ratio >= FLOOR);
endmodule

bind synth_prog_if synth_prog_if_chk #(
   .R_W(R_W), .A_W(A_W), .N_W(N_W), .R_MIN(R_MIN)
) i_chk (
   .clk(clk), .rst_n(rst_n), .le_rise(le_rise), .ctrl_bit(sr[0]),
   .sr_ratio(sr[R_W:1]), .ref_ratio(ref_ratio), .presc_sel(presc_sel),
   .swallow_cnt(swallow_cnt), .main_cnt(main_cnt), .cfg_err(cfg_err));

// File: tb/test_synth_prog_if.sv
module test_synth_prog_if;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_clk = 1'b0;
   logic        ser_data = 1'b0;
   logic        ser_le = 1'b0;
   logic [13:0] ref_ratio;
   logic        presc_sel;
   logic [6:0]  swallow_cnt;
   logic [10:0] main_cnt;
   logic        cfg_err;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [13:0] exp_r;
   logic        exp_sw;
   logic [6:0]  exp_a;
   logic [10:0] exp_n;
   logic        exp_err;

   always #(CLK_PERIOD/2) clk = ~clk;

   synth_prog_if i_synth_prog_if (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
      .ser_le(ser_le), .ref_ratio(ref_ratio), .presc_sel(presc_sel),
      .swallow_cnt(swallow_cnt), .main_cnt(main_cnt), .cfg_err(cfg_err));

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      check({req, " ref_ratio"},   32'(ref_ratio),   32'(exp_r));
      check({req, " presc_sel"},   32'(presc_sel),   32'(exp_sw));
      check({req, " swallow_cnt"}, 32'(swallow_cnt), 32'(exp_a));
      check({req, " main_cnt"},    32'(main_cnt),    32'(exp_n));
      check({req, " cfg_err"},     32'(cfg_err),     32'(exp_err));
   endtask

   task automatic shift_bits(input logic [31:0] word, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         ser_data = word[i];
         idle(4);
         ser_clk = 1'b1;
         idle(4);
         ser_clk = 1'b0;
      end
      idle(4);
   endtask

   task automatic pulse_le();
      ser_le = 1'b1;
      idle(6);
      ser_le = 1'b0;
      idle(6);
   endtask

   task automatic send_ref(input logic [13:0] r, input logic sw);
      shift_bits({16'h0, sw, r, 1'b1}, 16);
      pulse_le();
   endtask

   task automatic send_div(input logic [10:0] n, input logic [6:0] a);
      shift_bits({13'h0, n, a, 1'b0}, 19);
      pulse_le();
   endtask

   task automatic t_reset();
      exp_r = 14'd8; exp_sw = 1'b0; exp_a = '0; exp_n = '0; exp_err = 1'b0;
      check_all("R1");
   endtask

   task automatic t_ref_load();
      send_ref(14'h1234, 1'b1);
      exp_r = 14'h1234; exp_sw = 1'b1;
      check_all("R3");
      send_ref(14'h0a5c, 1'b0);
      exp_r = 14'h0a5c; exp_sw = 1'b0;
      check_all("R3");
   endtask

   task automatic t_div_load();
      send_div(11'h5a3, 7'h2c);
      exp_n = 11'h5a3; exp_a = 7'h2c;
      check_all("R4");
      send_div(11'h7ff, 7'h01);
      exp_n = 11'h7ff; exp_a = 7'h01;
      check_all("R4");
   endtask

   task automatic t_bounds();
      send_ref(14'd8, 1'b1);
      exp_r = 14'd8; exp_sw = 1'b1;
      check_all("R8");
      send_ref(14'd16383, 1'b0);
      exp_r = 14'd16383; exp_sw = 1'b0;
      check_all("R8");
   endtask

   task automatic t_reject();
      send_ref(14'd7, 1'b1);
      exp_err = 1'b1;
      check_all("R5");
      send_ref(14'd0, 1'b1);
      check_all("R5");
   endtask

   task automatic t_err_clear();
      send_div(11'h123, 7'h45);
      exp_n = 11'h123; exp_a = 7'h45;
      check_all("R6");
      send_ref(14'd100, 1'b1);
      exp_r = 14'd100; exp_sw = 1'b1; exp_err = 1'b0;
      check_all("R6");
   endtask

   task automatic t_data_only();
      shift_bits({16'h0, 1'b0, 14'd321, 1'b1}, 16);
      for (int i = 0; i < 9; i++) begin
         ser_data = ~ser_data;
         idle(5);
      end
      pulse_le();
      exp_r = 14'd321; exp_sw = 1'b0;
      check_all("R2");
   endtask

   task automatic t_single_load();
      shift_bits({13'h0, 11'h2aa, 7'h55, 1'b0}, 19);
      ser_le = 1'b1;
      idle(6);
      exp_n = 11'h2aa; exp_a = 7'h55;
      check_all("R7");
      shift_bits({16'h0, 1'b1, 14'd999, 1'b1}, 16);
      check_all("R7");
      ser_le = 1'b0;
      idle(6);
      check_all("R7");
      pulse_le();
      exp_r = 14'd999; exp_sw = 1'b1;
      check_all("R7");
   endtask

   initial begin
      idle(5);
      rst_n = 1'b1;
      idle(3);
      t_reset();
      t_ref_load();
      t_div_load();
      t_bounds();
      t_reject();
      t_err_clear();
      t_data_only();
      t_single_load();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule